// File: doc/BRIEF.md
# Clock Phase Delay Encoder

This block turns a requested clock phase, given in whole degrees, into the control word for a two-stage delay line. The first stage shifts by whole quarter periods. The second stage is a chain of fine cells, each taken to be 60 ps; the real cell can lie anywhere from 44 ps to 77 ps. The number of fine cells that one degree needs depends on the card clock rate, so the encoder divides by a rate-derived term. It rounds the result to the nearest cell and saturates it at the width of the count field.

The same block also works the other way. It decodes a control word back into an approximate phase, using the same nominal cell delay and the same clock rate. One shared restoring divider serves both operations. An operation starts on a single-cycle strobe, and a single-cycle done pulse marks its end. The error flag keeps its value until the next done.

Top module: `phdly_enc`

## Requirements
- R1: After reset, done_o, err_o, busy_o, ctl_word_o and phase_o are all zero.
- R2: On an encode, the quadrant (phase_i / 90, a value from 0 to 3) is placed in ctl_word_o bits 2:1, and bit 0 is always 0.
- R3: On an encode, the fine count is (rem*10000000 + D/2) / D with D = rate_khz_i*216 and rem = phase_i mod 90. It is placed in ctl_word_o bits 10:3.
- R4: A fine count above 255 is written as 255.
- R5: ctl_word_o bit 11 (fine enable) is 1 exactly when bits 10:3 are nonzero.
- R6: ctl_word_o bits 31:16 hold the write mask 16'h0FFE, and bits 15:12 are 0.
- R7: An encode with rate_khz_i = 0, or with phase_i >= 360, ends with done_o and err_o = 1 and leaves ctl_word_o unchanged.
- R8: A decode of ctl_i with rate_khz_i != 0 sets phase_o to (90*ctl_i[2:1] + F) mod 360. F = (ctl_i[10:3]*216*(rate_khz_i/10) + 500000) / 1000000 when ctl_i[11] = 1, and F = 0 otherwise. The count field has no effect when ctl_i[11] = 0.
- R9: A decode with rate_khz_i = 0 sets phase_o to 0 with err_o = 0.
- R10: Each accepted operation gives exactly one single-cycle done_o pulse. err_o changes only together with done_o.
- R11: A start_i asserted while busy_o = 1 is ignored: it produces no extra done and does not change the result in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle |
| decode_i | input | 1 | 1 = decode ctl_i, 0 = encode phase_i |
| phase_i | input | 9 | Requested phase in degrees |
| rate_khz_i | input | RATE_W | Card clock rate in kHz |
| ctl_i | input | 16 | Control word data half to decode |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished, one cycle |
| err_o | output | 1 | Last operation failed, held until the next done |
| ctl_word_o | output | 32 | Masked control word: mask in 31:16, data in 15:0 |
| phase_o | output | 9 | Decoded phase in degrees |

## Verification
The assertions assume that the divider is launched only from the idle state and always with a nonzero divisor. The top level guarantees this by catching a zero rate before it launches. They also assume that the error flag and the word move only on a done cycle. The stimulus drives start_i for exactly one cycle and holds every operand steady until the result arrives. The one exception is a deliberate second strobe during a busy interval, and that strobe carries different operands so that any effect it had would show. Rates are kept within RATE_W bits. Counts come from a rate range that covers rounding, saturation and wrap past 360.

// File: rtl/phdly_pkg.sv
package phdly_pkg;
  typedef enum logic {S_IDLE = 1'b0, S_DIV = 1'b1} phdly_state_e;

  localparam int unsigned QUAD_DEG  = 90;
  localparam int unsigned FULL_DEG  = 360;
  localparam int unsigned CELL_K    = 216;      // 6 * 36: nominal cell scale
  localparam int unsigned ENC_SCALE = 10000000;
  localparam int unsigned DEC_SCALE = 1000000;
  localparam int unsigned FINE_MAX  = 255;
  localparam logic [15:0] WR_MASK   = 16'h0FFE;

  function automatic logic [31:0] pack_word(logic en, logic [7:0] cnt, logic [1:0] quad);
    return {WR_MASK, 4'b0000, en, cnt, quad, 1'b0};
  endfunction
endpackage

// File: rtl/phdly_split.sv
module phdly_split (
  input  logic [8:0] phase_i,
  output logic [1:0] quad_o,
  output logic [6:0] rem_o,
  output logic       over_o
);
  import phdly_pkg::*;

  always_comb begin
    over_o = (phase_i >= 9'(FULL_DEG));
    quad_o = 2'd0;
    rem_o  = phase_i[6:0];
    for (int k = 1; k < 4; k++) begin
      if (phase_i >= 9'(k * QUAD_DEG)) begin
        quad_o = 2'(k);
        rem_o  = 7'(phase_i - 9'(k * QUAD_DEG));
      end
    end
  end
endmodule

// File: rtl/phdly_div.sv
module phdly_div #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [DW-1:0] dvd_i,
  input  logic [DW-1:0] dsr_i,
  output logic          valid_o,
  output logic [DW-1:0] quo_o
);
  localparam int CW = $clog2(DW + 1);

  logic          run_q, run_n;
  logic          valid_q, valid_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] acc_q, acc_n;
  logic [DW:0]   rem_q, rem_n;
  logic [DW-1:0] dsr_q, dsr_n;
  logic [DW:0]   trial;
  logic          fits;

  always_comb begin
    trial   = {rem_q[DW-1:0], acc_q[DW-1]};
    fits    = (trial >= {1'b0, dsr_q});
    run_n   = run_q;
    valid_n = 1'b0;
    cnt_n   = cnt_q;
    acc_n   = acc_q;
    rem_n   = rem_q;
    dsr_n   = dsr_q;
    if (go_i && !run_q) begin
      run_n = 1'b1;
      cnt_n = CW'(DW);
      acc_n = dvd_i;
      rem_n = '0;
      dsr_n = dsr_i;
    end else if (run_q) begin
      rem_n = fits ? (trial - {1'b0, dsr_q}) : trial;
      acc_n = {acc_q[DW-2:0], fits};
      cnt_n = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        run_n   = 1'b0;
        valid_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
      acc_q   <= '0;
      rem_q   <= '0;
      dsr_q   <= '0;
    end else begin
      run_q   <= run_n;
      valid_q <= valid_n;
      cnt_q   <= cnt_n;
      acc_q   <= acc_n;
      rem_q   <= rem_n;
      dsr_q   <= dsr_n;
    end
  end

  assign valid_o = valid_q;
  assign quo_o   = acc_q;

  // R11: the controller never relaunches the divider mid-run
  assert_no_relaunch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !run_q);
  // R3: a finished division leaves a remainder below the divisor
  assert_rem_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (rem_q < {1'b0, dsr_q}));
endmodule

// File: rtl/phdly_enc.sv
module phdly_enc #(
  parameter int RATE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              decode_i,
  input  logic [8:0]        phase_i,
  input  logic [RATE_W-1:0] rate_khz_i,
  input  logic [15:0]       ctl_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [31:0]       ctl_word_o,
  output logic [8:0]        phase_o
);
  import phdly_pkg::*;

  localparam int DW = RATE_W + 16;

  phdly_state_e  state_q, state_n;
  logic          dec_q, dec_n;
  logic [1:0]    quad_q, quad_n;
  logic          done_q, done_n;
  logic          err_q, err_n;
  logic [31:0]   word_q, word_n;
  logic [8:0]    phase_q, phase_n;

  logic [1:0]    enc_quad;
  logic [6:0]    enc_rem;
  logic          enc_over;
  logic          rate_zero;
  logic [DW-1:0] enc_dsr, enc_dvd, dec_prod, dec_dvd;
  logic [RATE_W-1:0] rate_div10;
  logic          go;
  logic [DW-1:0] div_dvd, div_dsr, quo;
  logic          div_valid;
  logic [7:0]    cnt_sat;
  logic [DW:0]   dec_sum;

  phdly_split split_i (
    .phase_i (phase_i),
    .quad_o  (enc_quad),
    .rem_o   (enc_rem),
    .over_o  (enc_over)
  );

  always_comb begin
    rate_zero  = (rate_khz_i == '0);
    enc_dsr    = DW'(rate_khz_i) * DW'(CELL_K);
    enc_dvd    = DW'(enc_rem) * DW'(ENC_SCALE) + (enc_dsr >> 1);
    rate_div10 = rate_khz_i / RATE_W'(10);
    dec_prod   = ctl_i[11] ? (DW'(ctl_i[10:3]) * DW'(CELL_K) * DW'(rate_div10)) : '0;
    dec_dvd    = dec_prod + DW'(DEC_SCALE / 2);
    div_dvd    = decode_i ? dec_dvd : enc_dvd;
    div_dsr    = decode_i ? DW'(DEC_SCALE) : enc_dsr;
  end

  phdly_div #(.DW(DW)) div_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (go),
    .dvd_i   (div_dvd),
    .dsr_i   (div_dsr),
    .valid_o (div_valid),
    .quo_o   (quo)
  );

  always_comb begin
    cnt_sat = (quo > DW'(FINE_MAX)) ? 8'(FINE_MAX) : quo[7:0];
    dec_sum = {1'b0, quo} + ((DW+1)'(quad_q) * (DW+1)'(QUAD_DEG));
    state_n = state_q;
    dec_n   = dec_q;
    quad_n  = quad_q;
    done_n  = 1'b0;
    err_n   = err_q;
    word_n  = word_q;
    phase_n = phase_q;
    go      = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          if (decode_i) begin
            if (rate_zero) begin
              done_n  = 1'b1;
              err_n   = 1'b0;
              phase_n = '0;
            end else begin
              go      = 1'b1;
              dec_n   = 1'b1;
              quad_n  = ctl_i[2:1];
              state_n = S_DIV;
            end
          end else begin
            if (rate_zero || enc_over) begin
              done_n = 1'b1;
              err_n  = 1'b1;
            end else begin
              go      = 1'b1;
              dec_n   = 1'b0;
              quad_n  = enc_quad;
              state_n = S_DIV;
            end
          end
        end
      end
      S_DIV: begin
        if (div_valid) begin
          state_n = S_IDLE;
          done_n  = 1'b1;
          err_n   = 1'b0;
          if (dec_q) phase_n = 9'(dec_sum % (DW+1)'(FULL_DEG));
          else       word_n  = pack_word(cnt_sat != 8'd0, cnt_sat, quad_q);
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dec_q   <= 1'b0;
      quad_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      word_q  <= '0;
      phase_q <= '0;
    end else begin
      state_q <= state_n;
      dec_q   <= dec_n;
      quad_q  <= quad_n;
      done_q  <= done_n;
      err_q   <= err_n;
      word_q  <= word_n;
      phase_q <= phase_n;
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign ctl_word_o = word_q;
  assign phase_o    = phase_q;

  // R10: done lasts one cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R10: the error flag moves only with done
  assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_q) |-> done_q);
  // R7: the word changes only on a successful completion
  assert_word_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_q) |-> (done_q && !err_q));
  // R5: enable bit agrees with the stored count
  assert_en_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_q[11] == (word_q[10:3] != 8'd0));
  // R8: decoded phase stays below a full turn
  assert_dec_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < 9'd360);
endmodule

// File: tb/phdly_enc_tb_top.sv
module phdly_enc_tb_top;
  localparam int RATE_W = 20;

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic              decode_i;
  logic [8:0]        phase_i;
  logic [RATE_W-1:0] rate_khz_i;
  logic [15:0]       ctl_i;
  logic              busy_o, done_o, err_o;
  logic [31:0]       ctl_word_o;
  logic [8:0]        phase_o;

  typedef struct {
    bit          dec;
    bit          err;
    logic [31:0] word;
    logic [8:0]  phase;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          nvec, nfail, pushed, popped;
  logic [31:0] mdl_word;
  logic [8:0]  mdl_phase;

  phdly_enc #(.RATE_W(RATE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .decode_i(decode_i),
    .phase_i(phase_i), .rate_khz_i(rate_khz_i), .ctl_i(ctl_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .ctl_word_o(ctl_word_o), .phase_o(phase_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] exp_word(int d, longint r);
    longint unsigned rem, dv, c;
    logic [1:0] quad;
    quad = 2'(d / 90);
    rem  = longint'(d % 90);
    dv   = r * 216;
    c    = (rem * 10000000 + dv / 2) / dv;
    if (c > 255) c = 255;
    return {16'h0FFE, 4'b0000, (c != 0), 8'(c), quad, 1'b0};
  endfunction

  function automatic logic [8:0] exp_phase(logic [15:0] w, longint r);
    longint unsigned q;
    if (r == 0) return 9'd0;
    q = 0;
    if (w[11]) q = (longint'(w[10:3]) * 216 * (r / 10) + 500000) / 1000000;
    return 9'((longint'(w[2:1]) * 90 + q) % 360);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic push_op(bit dec, int ph, longint r, logic [15:0] w, string req);
    exp_t it;
    it.dec = dec;
    it.req = req;
    if (dec) begin
      it.err    = 1'b0;
      mdl_phase = exp_phase(w, r);
    end else if (r == 0 || ph >= 360) begin
      it.err = 1'b1;
    end else begin
      it.err   = 1'b0;
      mdl_word = exp_word(ph, r);
    end
    it.word  = mdl_word;
    it.phase = mdl_phase;
    sb.push_back(it);
    pushed++;
  endtask

  task automatic run_op(bit dec, int ph, longint r, logic [15:0] w, string req);
    push_op(dec, ph, r, w, req);
    @(negedge clk);
    start_i    = 1'b1;
    decode_i   = dec;
    phase_i    = 9'(ph);
    rate_khz_i = RATE_W'(r);
    ctl_i      = w;
    @(negedge clk);
    start_i = 1'b0;
    while (popped != pushed) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb.size() == 0) begin
        check(1'b0, "R10/R11", "unexpected done", 1, 0);
      end else begin
        exp_t it;
        it = sb.pop_front();
        check(err_o == it.err, it.req, "err", err_o, it.err);
        check(ctl_word_o == it.word, it.req, "word", ctl_word_o, it.word);
        if (it.dec) check(phase_o == it.phase, it.req, "phase", phase_o, it.phase);
        popped++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    nvec = 0; nfail = 0; pushed = 0; popped = 0;
    mdl_word = '0; mdl_phase = '0;
    start_i = 1'b0; decode_i = 1'b0; phase_i = '0; rate_khz_i = '0; ctl_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!done_o && !err_o && !busy_o, "R1", "flags", {done_o, err_o, busy_o}, 0);
    check(ctl_word_o == 32'h0 && phase_o == 9'h0, "R1", "outputs", ctl_word_o, 0);

    run_op(0, 45, 50000, 16'h0, "R3");
    run_op(0, 135, 50000, 16'h0, "R2");
    run_op(0, 90, 50000, 16'h0, "R5");   // zero fine count, enable clear
    run_op(0, 0, 50000, 16'h0, "R2");
    run_op(0, 359, 50000, 16'h0, "R3");
    run_op(0, 300, 150000, 16'h0, "R3");
    run_op(0, 200, 200000, 16'h0, "R6");
    run_op(0, 45, 400, 16'h0, "R4");     // saturates at 255
    check(ctl_word_o[10:3] == 8'hFF && ctl_word_o[11], "R4", "sat count", ctl_word_o[11:3], 9'h1FF);
    check(ctl_word_o[31:16] == 16'h0FFE && ctl_word_o[15:12] == 4'h0, "R6", "mask", ctl_word_o, 32'h0FFE0000);
    run_op(0, 100, 0, 16'h0, "R7");      // zero rate
    run_op(0, 360, 50000, 16'h0, "R7");  // out of range
    repeat (3) @(negedge clk);
    check(err_o == 1'b1, "R10", "err held", err_o, 1);

    run_op(1, 0, 50000, exp_word(45, 50000)[15:0], "R8");
    run_op(1, 0, 200000, {4'h0, 1'b1, 8'hFF, 2'd3, 1'b0}, "R8"); // wraps past 360
    run_op(1, 0, 50000, {4'h0, 1'b0, 8'hA5, 2'd2, 1'b0}, "R8");  // count ignored
    check(phase_o == 9'd180, "R8", "enable clear", phase_o, 180);
    run_op(1, 0, 0, {4'h0, 1'b1, 8'h40, 2'd1, 1'b0}, "R9");
    check(err_o == 1'b0, "R9", "no err", err_o, 0);

    // R11: second start while busy must be ignored
    push_op(0, 77, 80000, 16'h0, "R11");
    @(negedge clk);
    start_i = 1'b1; decode_i = 1'b0; phase_i = 9'd77; rate_khz_i = RATE_W'(80000);
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    check(busy_o == 1'b1, "R11", "busy", busy_o, 1);
    start_i = 1'b1; phase_i = 9'd250; rate_khz_i = RATE_W'(1000);
    @(negedge clk);
    start_i = 1'b0;
    while (popped != pushed) @(negedge clk);
    repeat (50) @(negedge clk);
    check(sb.size() == 0 && !busy_o, "R11", "idle after", busy_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule